// File: doc/BRIEF.md
# Prescaled Timebase Counter with Selectable Clock Source

This block keeps a free-running 24-bit time count for a timer subsystem. Each increment of the count is gated by a programmable prescaler. The prescaler advances on ticks from one of two sources, picked by a 2-bit source-select field:
- rising edges seen on an asynchronous external timer-clock pin, after synchronisation;
- a half-rate tick derived from the system clock.

A third setting stops the ticks altogether.

Software programs the source select and the 8-bit divide value through a simple write port. The running count is presented on a read-only 32-bit view word. In that word the count sits in the low bits and every bit above it reads as zero.

Top module: `tbase_ctr`

## Requirements
- R1: After reset the count is 0, the source select is 0 (external pin) and the divide value is 0.
- R2: With source select 0, each rising edge of the external pin gives exactly one prescaler tick, provided the pin holds each level for at least two clocks. With a divide value of 0, the count steps two clock edges after the edge that first samples the pin high.
- R3: A level held on the external pin produces no further ticks; only a low-to-high transition counts.
- R4: Source select 2 gives the prescaler one tick on every second system clock edge. With a divide value of 0, the count rises by 1 every two clocks.
- R5: The control word at write address 0 carries the divide value P in bits [7:0] and the source select in bits [9:8]. The count steps once per P+1 prescaler ticks, for P from 0 to 255.
- R6: A new P takes effect at the next prescaler reload. The division period already in progress completes with the old value.
- R7: Source select 3 stops the ticks, and the count holds its value.
- R8: Source select 1 is reserved and acts exactly like 3: the count holds.
- R9: A write that changes the source select restarts the prescaler with the newly written P. The first increment from the new source comes only after a full P+1 ticks of that source.
- R10: The count wraps from all ones to 0 with no other effect, and it never changes by more than 1 per clock.
- R11: The view output shows the count in bits [CNT_W-1:0] with all higher bits at 0. A write to address 1 (the view word) changes nothing.
- R12: A control write is registered on the clock edge where wr_en is high. The source it selects governs ticks from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_in | input | 1 | Asynchronous external timer clock pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 = control word, 1 = view word (ignored) |
| wr_data | input | 32 | Write data |
| view_data | output | 32 | Read-only view of the count, zero-padded above the count |

## Verification
The count is the only output, so every result is timed against the edge it is due on. An external-pin edge reaches the count on the second edge after the pin is first sampled high. A half-rate tick or a prescaler reload shows on the same edge that consumes the tick. A control write steers the tick source from the next edge. The bench keeps a behavioural model that applies these latencies edge by edge and compares the view word one time unit after every rising clock edge. Directed checks then confirm the exact latencies, the hold cases and the wrap against hand-computed totals.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    typedef enum logic [1:0] {
        SRC_PIN  = 2'b00,
        SRC_RSVD = 2'b01,
        SRC_HALF = 2'b10,
        SRC_OFF  = 2'b11
    } src_sel_e;

    localparam int SEL_W     = 2;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_VIEW = 1'b1;
endpackage

// File: rtl/tbase_pin_edge.sv
module tbase_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise_pulse
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_async};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        rise_pulse = st_q.sync[SYNC_STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tbase_half_tick.sv
module tbase_half_tick (
    input  logic clk,
    input  logic rst_n,
    output logic half_tick
);
    typedef struct packed {
        logic toggle;
    } half_st_t;

    half_st_t st_d, st_q;

    always_comb begin
        st_d.toggle = ~st_q.toggle;
        half_tick   = st_q.toggle;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tbase_presc.sv
module tbase_presc #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [DIV_W-1:0] restart_val,
    input  logic [DIV_W-1:0] div_val,
    output logic             strobe
);
    typedef struct packed {
        logic [DIV_W-1:0] remain;
    } presc_st_t;

    presc_st_t st_d, st_q;
    logic      at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.remain == '0);
        strobe  = tick & at_zero & ~restart;
        if (restart) begin
            st_d.remain = restart_val;
        end else if (tick) begin
            st_d.remain = at_zero ? div_val : st_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tbase_ctr.sv
module tbase_ctr
    import tbase_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DIV_W  = 8,
    parameter int VIEW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_in,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [VIEW_W-1:0] wr_data,
    output logic [VIEW_W-1:0] view_data
);
    localparam int SEL_LSB = DIV_W;

    typedef struct packed {
        src_sel_e         sel;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] count;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             pin_pulse;
    logic             half_tick;
    logic             src_tick;
    logic             restart;
    logic             strobe;
    logic             ctrl_wr;
    src_sel_e         new_sel;
    logic [DIV_W-1:0] new_div;
    logic [1:0]       sel_now;
    logic [CNT_W-1:0] count_now;

    tbase_pin_edge #(.SYNC_STAGES(2)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (ext_clk_in),
        .rise_pulse (pin_pulse)
    );

    tbase_half_tick u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick)
    );

    tbase_presc #(.DIV_W(DIV_W)) u_presc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (src_tick),
        .restart     (restart),
        .restart_val (new_div),
        .div_val     (st_q.div),
        .strobe      (strobe)
    );

    always_comb begin
        st_d    = st_q;
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
        new_sel = src_sel_e'(wr_data[SEL_LSB +: SEL_W]);
        new_div = wr_data[DIV_W-1:0];
        restart = ctrl_wr && (new_sel != st_q.sel);

        unique case (st_q.sel)
            SRC_PIN:  src_tick = pin_pulse;
            SRC_HALF: src_tick = half_tick;
            default:  src_tick = 1'b0;
        endcase

        if (ctrl_wr) begin
            st_d.sel = new_sel;
            st_d.div = new_div;
        end
        st_d.count = st_q.count + CNT_W'(strobe);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel   <= SRC_PIN;
            st_q.div   <= '0;
            st_q.count <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_now   = st_q.sel;
    assign count_now = st_q.count;
    assign view_data = VIEW_W'(st_q.count);
endmodule

// File: rtl/tbase_ctr_chk.sv
module tbase_ctr_chk #(
    parameter int CNT_W  = 24,
    parameter int VIEW_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        sel_q,
    input logic [CNT_W-1:0]  count_q,
    input logic [VIEW_W-1:0] view,
    input logic              pulse,
    input logic              tick,
    input logic              strobe
);
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    assert_strobe_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> tick);

    assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 2'b11) |=> $stable(count_q));

    assert_hold_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 2'b01) |=> $stable(count_q));

    assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count_q == $past(count_q)) ||
                 (count_q == CNT_W'($past(count_q) + 1'b1)));

    assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (view[VIEW_W-1:CNT_W] == '0) && (view[CNT_W-1:0] == count_q));
endmodule

bind tbase_ctr tbase_ctr_chk #(.CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_q   (sel_now),
    .count_q (count_now),
    .view    (view_data),
    .pulse   (pin_pulse),
    .tick    (src_tick),
    .strobe  (strobe)
);

// File: tb/tbase_ctr_test.sv
module tbase_ctr_test;
    localparam int TB_CNT_W = 10;
    localparam int MASK     = (1 << TB_CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] view_data;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // behavioural model state
    bit pin_hist[$];
    int n_edges = 0;
    int m_sel = 0;
    int m_div = 0;
    int m_left = 0;
    int m_cnt = 0;
    int prev_view = 0;
    bit wrapped = 0;

    always #4 clk = ~clk;

    tbase_ctr #(.CNT_W(TB_CNT_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_clk_in (ext_clk_in),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .view_data  (view_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one clock: model the coming edge, then compare after it
    task automatic step();
        bit pulse, half, tick, ctrl, restart;
        int nsel;
        pulse = pin_hist[1] && !pin_hist[2];
        half  = (n_edges % 2) == 1;
        tick  = (m_sel == 0) ? pulse : (m_sel == 2) ? half : 1'b0;
        ctrl  = wr_en && (wr_addr == 1'b0);
        nsel  = int'(wr_data[9:8]);
        restart = ctrl && (nsel != m_sel);
        if (restart) begin
            m_left = int'(wr_data[7:0]);
        end else if (tick) begin
            if (m_left == 0) begin
                m_left = m_div;
                m_cnt  = (m_cnt + 1) & MASK;
            end else begin
                m_left--;
            end
        end
        if (ctrl) begin
            m_sel = nsel;
            m_div = int'(wr_data[7:0]);
        end
        pin_hist.push_front(ext_clk_in);
        void'(pin_hist.pop_back());
        n_edges++;
        @(posedge clk);
        #1;
        check(view_data == 32'(m_cnt), cur_req, view_data, m_cnt);
        if (prev_view == MASK && view_data == 0) wrapped = 1;
        prev_view = int'(view_data);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input bit addr, input logic [31:0] data);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        step();
        wr_en = 1'b0; wr_data = '0; wr_addr = 1'b0;
    endtask

    task automatic pin_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = 1'b1; steps(3);
            ext_clk_in = 1'b0; steps(3);
        end
    endtask

    initial begin
        int c0;
        for (int i = 0; i < 4; i++) pin_hist.push_back(1'b0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(view_data == 0, "R1 reset count", view_data, 0);

        // R2 latency
        cur_req = "R2";
        c0 = int'(view_data);
        ext_clk_in = 1'b1; step(); step();
        check(view_data == 32'(c0), "R2 not yet", view_data, c0);
        step();
        check(view_data == 32'(c0 + 1), "R2 step on 2nd edge after sample", view_data, c0 + 1);
        // R3 level has no effect
        cur_req = "R3";
        steps(40);
        check(view_data == 32'(c0 + 1), "R3 level held", view_data, c0 + 1);
        ext_clk_in = 1'b0; steps(3);
        cur_req = "R2";
        c0 = int'(view_data);
        pin_pulse(10);
        check(view_data == 32'(c0 + 10), "R2 ten edges", view_data, c0 + 10);

        // R4 half rate, P = 0 (select in bits [9:8], P in [7:0])
        cur_req = "R12";
        wr(1'b0, 32'h0000_0200);
        cur_req = "R4";
        steps(4);
        c0 = int'(view_data);
        steps(20);
        check(view_data == 32'(c0 + 10), "R4 half rate", view_data, c0 + 10);

        // R5 P = 4
        cur_req = "R5";
        wr(1'b0, 32'h0000_0204);
        steps(20);
        c0 = int'(view_data);
        steps(100);
        check(view_data == 32'((c0 + 10) & MASK), "R5 divide by 5", view_data, (c0 + 10) & MASK);

        // R6 P changes at next reload
        cur_req = "R6";
        steps(3);
        wr(1'b0, 32'h0000_0201);
        steps(40);
        wr(1'b0, 32'h0000_0206);
        steps(40);

        // R5 largest divide
        cur_req = "R5";
        wr(1'b0, 32'h0000_02FF);
        steps(1100);

        // R9 restart on source change, P = 3
        cur_req = "R9";
        wr(1'b0, 32'h0000_0003);
        c0 = int'(view_data);
        pin_pulse(3);
        check(view_data == 32'(c0), "R9 three edges no step", view_data, c0);
        pin_pulse(1);
        check(view_data == 32'((c0 + 1) & MASK), "R9 fourth edge steps", view_data, (c0 + 1) & MASK);

        // R7 stopped
        cur_req = "R7";
        wr(1'b0, 32'h0000_0300);
        c0 = int'(view_data);
        pin_pulse(5); steps(50);
        check(view_data == 32'(c0), "R7 hold", view_data, c0);

        // R8 reserved code
        cur_req = "R8";
        wr(1'b0, 32'h0000_0100);
        pin_pulse(5); steps(50);
        check(view_data == 32'(c0), "R8 hold", view_data, c0);

        // R11 write to view word ignored
        cur_req = "R11";
        wr(1'b1, 32'hFFFF_FFFF);
        check(view_data == 32'(c0), "R11 view write", view_data, c0);
        pin_pulse(3); steps(20);
        check(view_data == 32'(c0), "R11 control untouched", view_data, c0);
        check(view_data[31:TB_CNT_W] == 0, "R11 upper bits zero", view_data, c0);

        // R10 wrap
        cur_req = "R10";
        wr(1'b0, 32'h0000_0200);
        steps(2 * (MASK + 1) + 8);
        check(wrapped, "R10 wrap seen", wrapped, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule